// File: doc/BRIEF.md
# Key Slot Free-List Allocator

This block hands out hardware key slot numbers to software contexts and takes them back when a context is finished with its key. The slots that can be handed out sit in a first-in-first-out free list. An allocate request takes the slot at the head of that list. A release request appends the slot at the tail. One slot number is set aside for a key that is loaded at boot. That slot never enters the free list and can never be handed out.

Requests arrive as single-cycle strobes. Every response is registered, so it appears on the outputs after the clock edge that samples the request. A grant reports a valid slot number; when the pool is empty, a fail flag is raised instead. A release of a slot that is already free is refused and flagged with a one-cycle error pulse. The number of free slots is always visible on `free_cnt`.

Top module: `keyslot_alloc`

## Requirements
- R1: A synchronous active-high reset fills the free list with slots 0, 1, 2, 3, 5, 6, 7 in that order. It sets `free_cnt` to 7 and holds `grant_vld`, `grant_fail` and `dfree_err` low.
- R2: An allocate request against a non-empty list takes the head slot. In the next cycle it drives `grant_vld` high with that slot on `grant_slot`, and `free_cnt` falls by one.
- R3: An allocate request against an empty list, with no usable release in the same cycle, raises `grant_fail` for one cycle, keeps `grant_vld` low and leaves `free_cnt` at 0. With no allocate request, neither `grant_vld` nor `grant_fail` is raised.
- R4: A release of a slot that is not in the free list appends it at the tail and raises `free_cnt` by one. Slots released earlier are granted earlier.
- R5: Reserved slot 4 is never granted. A release naming slot 4 changes nothing: `free_cnt`, `dfree_err` and later grants are unaffected.
- R6: A release of a slot already in the free list is ignored: the list and `free_cnt` are unchanged. `dfree_err` pulses high for one cycle.
- R7: When allocate and release arrive in the same cycle, the release is taken first. On an empty list the released slot is granted at once and `free_cnt` stays 0. On a non-empty list the head is granted and the released slot goes to the tail.
- R8: `free_cnt` never exceeds 7, the number of non-reserved slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Allocate strobe |
| rel_req | input | 1 | Release strobe |
| rel_slot | input | 3 | Slot number being released |
| grant_vld | output | 1 | A slot was granted (registered) |
| grant_slot | output | 3 | Granted slot number, valid with `grant_vld` |
| grant_fail | output | 1 | Allocation refused because the pool was empty |
| dfree_err | output | 1 | One-cycle pulse on a release of an already free slot |
| free_cnt | output | 4 | Number of slots in the free list |

## Verification
An allocation and a release can fall in the same clock cycle. The bench drives them together in three situations:
- With free slots present, it checks that the head is granted and that the released slot reappears behind the others.
- With the pool drained to zero, it checks that the released slot is granted directly and the count stays at zero.
- With the release naming a slot that is already free, it checks that the head is still granted and the double-free pulse fires.

In each case the grant slot, the fail flag, the error pulse and the count are compared in the cycle after the strobes. Later grants are then compared to confirm the tail order.

// File: rtl/keyslot_pkg.sv
package keyslot_pkg;
  localparam int KS_NUM_SLOTS     = 8;
  localparam int KS_RESERVED_SLOT = 4;

  // Slot held by free-list entry idx right after reset: ascending order, reserved one skipped.
  function automatic int ks_init_slot(input int idx, input int reserved);
    return (idx < reserved) ? idx : idx + 1;
  endfunction
endpackage

// File: rtl/keyslot_ring.sv
module keyslot_ring
  import keyslot_pkg::*;
#(
  parameter int DEPTH    = KS_NUM_SLOTS,
  parameter int RESERVED = KS_RESERVED_SLOT,
  localparam int W       = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int INIT_N  = DEPTH - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head_data,
  output logic [CNT_W-1:0] level
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_ptr, wr_ptr;

  function automatic logic [W-1:0] bump(input logic [W-1:0] p);
    return (p == W'(DEPTH - 1)) ? '0 : p + W'(1);
  endfunction

  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= (i < INIT_N) ? W'(ks_init_slot(i, RESERVED)) : '0;
      end
      rd_ptr <= '0;
      wr_ptr <= W'(INIT_N);
      level  <= CNT_W'(INIT_N);
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop) begin
        rd_ptr <= bump(rd_ptr);
      end
      case ({push, pop})
        2'b10:   level <= level + CNT_W'(1);
        2'b01:   level <= level - CNT_W'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/keyslot_bitmap.sv
module keyslot_bitmap
  import keyslot_pkg::*;
#(
  parameter int N        = KS_NUM_SLOTS,
  parameter int RESERVED = KS_RESERVED_SLOT,
  localparam int W       = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic [W-1:0] set_idx,
  input  logic         clr_en,
  input  logic [W-1:0] clr_idx,
  output logic [N-1:0] in_pool
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    if (g == RESERVED) begin : g_rsvd
      assign in_pool[g] = 1'b0;
    end else begin : g_free
      always_ff @(posedge clk) begin
        if (rst) begin
          in_pool[g] <= 1'b1;
        end else if (set_en && set_idx == W'(g)) begin
          in_pool[g] <= 1'b1;
        end else if (clr_en && clr_idx == W'(g)) begin
          in_pool[g] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/keyslot_alloc.sv
module keyslot_alloc
  import keyslot_pkg::*;
#(
  parameter int NUM_SLOTS     = KS_NUM_SLOTS,
  parameter int RESERVED_SLOT = KS_RESERVED_SLOT,
  localparam int SLOT_W       = $clog2(NUM_SLOTS),
  localparam int CNT_W        = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_req,
  input  logic              rel_req,
  input  logic [SLOT_W-1:0] rel_slot,
  output logic              grant_vld,
  output logic [SLOT_W-1:0] grant_slot,
  output logic              grant_fail,
  output logic              dfree_err,
  output logic [CNT_W-1:0]  free_cnt
);
  logic [SLOT_W-1:0]    head;
  logic [NUM_SLOTS-1:0] in_pool;
  logic rsvd_hit, in_range, rel_ok, dbl_free, nonempty;
  logic do_pop, bypass, do_push;

  // Release qualification: reserved and out-of-range numbers are dropped silently.
  assign rsvd_hit = (rel_slot == SLOT_W'(RESERVED_SLOT));
  assign in_range = ({1'b0, rel_slot} < (SLOT_W + 1)'(NUM_SLOTS));
  assign rel_ok   = rel_req && in_range && !rsvd_hit && !in_pool[rel_slot];
  assign dbl_free = rel_req && in_range && !rsvd_hit &&  in_pool[rel_slot];

  // Release is ordered before allocate; on an empty list it feeds the grant directly.
  assign nonempty = (free_cnt != '0);
  assign do_pop   = alloc_req && nonempty;
  assign bypass   = alloc_req && !nonempty && rel_ok;
  assign do_push  = rel_ok && !bypass;

  keyslot_ring #(.DEPTH(NUM_SLOTS), .RESERVED(RESERVED_SLOT)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .push      (do_push),
    .push_data (rel_slot),
    .pop       (do_pop),
    .head_data (head),
    .level     (free_cnt)
  );

  keyslot_bitmap #(.N(NUM_SLOTS), .RESERVED(RESERVED_SLOT)) u_bitmap (
    .clk     (clk),
    .rst     (rst),
    .set_en  (do_push),
    .set_idx (rel_slot),
    .clr_en  (do_pop),
    .clr_idx (head),
    .in_pool (in_pool)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_vld  <= 1'b0;
      grant_slot <= '0;
      grant_fail <= 1'b0;
      dfree_err  <= 1'b0;
    end else begin
      grant_vld  <= do_pop || bypass;
      grant_slot <= do_pop ? head : (bypass ? rel_slot : '0);
      grant_fail <= alloc_req && !do_pop && !bypass;
      dfree_err  <= dbl_free;
    end
  end
endmodule

// File: rtl/keyslot_alloc_sva.sv
module keyslot_alloc_sva
  import keyslot_pkg::*;
#(
  parameter int NUM_SLOTS     = KS_NUM_SLOTS,
  parameter int RESERVED_SLOT = KS_RESERVED_SLOT,
  localparam int SLOT_W       = $clog2(NUM_SLOTS),
  localparam int CNT_W        = $clog2(NUM_SLOTS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              alloc_req,
  input logic              rel_req,
  input logic [SLOT_W-1:0] rel_slot,
  input logic              grant_vld,
  input logic [SLOT_W-1:0] grant_slot,
  input logic              grant_fail,
  input logic              dfree_err,
  input logic [CNT_W-1:0]  free_cnt
);
  p_grant_on_nonempty_r2: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && free_cnt != '0) |=> (grant_vld && !grant_fail));

  p_fail_on_empty_r3: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && !rel_req && free_cnt == '0) |=> (grant_fail && !grant_vld));

  p_no_req_no_resp_r3: assert property (@(posedge clk) disable iff (rst)
    !alloc_req |=> (!grant_vld && !grant_fail));

  p_never_reserved_r5: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> (grant_slot != SLOT_W'(RESERVED_SLOT)));

  p_dfree_needs_pool_r6: assert property (@(posedge clk) disable iff (rst)
    dfree_err |-> ($past(free_cnt) != '0));

  p_bypass_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && rel_req && free_cnt == '0 && rel_slot != SLOT_W'(RESERVED_SLOT))
    |=> (grant_vld && grant_slot == $past(rel_slot) && free_cnt == '0));

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    free_cnt <= CNT_W'(NUM_SLOTS - 1));
endmodule

bind keyslot_alloc keyslot_alloc_sva #(.NUM_SLOTS(NUM_SLOTS), .RESERVED_SLOT(RESERVED_SLOT)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .alloc_req  (alloc_req),
  .rel_req    (rel_req),
  .rel_slot   (rel_slot),
  .grant_vld  (grant_vld),
  .grant_slot (grant_slot),
  .grant_fail (grant_fail),
  .dfree_err  (dfree_err),
  .free_cnt   (free_cnt)
);

// File: tb/keyslot_alloc_bench.sv
`timescale 1ns/1ps
module keyslot_alloc_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       alloc_req, rel_req;
  logic [2:0] rel_slot;
  logic       grant_vld, grant_fail, dfree_err;
  logic [2:0] grant_slot;
  logic [3:0] free_cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  keyslot_alloc u_keyslot_alloc (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .rel_req(rel_req), .rel_slot(rel_slot),
    .grant_vld(grant_vld), .grant_slot(grant_slot), .grant_fail(grant_fail),
    .dfree_err(dfree_err), .free_cnt(free_cnt)
  );

  // {alloc, rel, rel_slot[2:0], exp_vld, exp_slot[2:0], exp_fail, exp_err, exp_cnt[3:0]}
  localparam int NV = 19;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0, 1'b0, 4'd6},  // R2 head 0
    {1'b1, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0, 1'b0, 4'd5},  // R2 head 1
    {1'b0, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 4'd6},  // R4 release 0 to tail
    {1'b0, 1'b1, 3'd4, 1'b0, 3'd0, 1'b0, 1'b0, 4'd6},  // R5 reserved release ignored
    {1'b0, 1'b1, 3'd3, 1'b0, 3'd0, 1'b0, 1'b1, 4'd6},  // R6 slot 3 already free
    {1'b1, 1'b1, 3'd1, 1'b1, 3'd2, 1'b0, 1'b0, 4'd6},  // R7 both, non-empty
    {1'b1, 1'b0, 3'd0, 1'b1, 3'd3, 1'b0, 1'b0, 4'd5},  // R2
    {1'b1, 1'b0, 3'd0, 1'b1, 3'd5, 1'b0, 1'b0, 4'd4},  // R5 skips 4
    {1'b1, 1'b0, 3'd0, 1'b1, 3'd6, 1'b0, 1'b0, 4'd3},  // R2
    {1'b1, 1'b0, 3'd0, 1'b1, 3'd7, 1'b0, 1'b0, 4'd2},  // R2
    {1'b1, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0, 1'b0, 4'd1},  // R4 tail order
    {1'b1, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0, 1'b0, 4'd0},  // R7 slot pushed with alloc
    {1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 1'b0, 4'd0},  // R3 empty
    {1'b1, 1'b1, 3'd6, 1'b1, 3'd6, 1'b0, 1'b0, 4'd0},  // R7 bypass on empty
    {1'b0, 1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 1'b0, 4'd1},  // R4
    {1'b0, 1'b1, 3'd3, 1'b0, 3'd0, 1'b0, 1'b0, 4'd2},  // R4
    {1'b1, 1'b1, 3'd2, 1'b1, 3'd2, 1'b0, 1'b1, 4'd1},  // R6 dfree with alloc
    {1'b1, 1'b0, 3'd0, 1'b1, 3'd3, 1'b0, 1'b0, 4'd0},  // R2
    {1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 4'd0}   // R3 idle
  };
  string tags [NV] = '{"R2", "R2", "R4", "R5", "R6", "R7", "R2", "R5", "R2", "R2",
                       "R4", "R7", "R3", "R7", "R4", "R4", "R6", "R2", "R3"};

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic r, input logic [2:0] s);
    @(negedge clk);
    alloc_req = a; rel_req = r; rel_slot = s;
    @(posedge clk);
    #1;
    alloc_req = 1'b0; rel_req = 1'b0; rel_slot = '0;
  endtask

  task automatic expect_out(input string tag, input logic v, input logic [2:0] sl,
                            input logic f, input logic e, input logic [3:0] c);
    chk(tag, "grant_vld", grant_vld, v);
    if (v) chk(tag, "grant_slot", grant_slot, sl);
    chk(tag, "grant_fail", grant_fail, f);
    chk(tag, "dfree_err", dfree_err, e);
    chk(tag, "free_cnt", free_cnt, c);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  initial begin
    rst = 1'b1; alloc_req = 1'b0; rel_req = 1'b0; rel_slot = '0;
    do_reset();
    expect_out("R1", 1'b0, 3'd0, 1'b0, 1'b0, 4'd7);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14], VEC[i][13], VEC[i][12:10]);
      expect_out(tags[i], VEC[i][9], VEC[i][8:6], VEC[i][5], VEC[i][4], VEC[i][3:0]);
    end

    // R1: reset mid-run restores the full pool in ascending order
    do_reset();
    expect_out("R1", 1'b0, 3'd0, 1'b0, 1'b0, 4'd7);
    // R8: releasing into a full pool cannot push the count past 7
    step(1'b0, 1'b1, 3'd0);
    expect_out("R8", 1'b0, 3'd0, 1'b0, 1'b1, 4'd7);
    for (int k = 0; k < 7; k++) begin
      step(1'b1, 1'b0, 3'd0);
      expect_out("R1", 1'b1, 3'((k < 4) ? k : k + 1), 1'b0, 1'b0, 4'(6 - k));
    end
    step(1'b1, 1'b0, 3'd0);
    expect_out("R3", 1'b0, 3'd0, 1'b1, 1'b0, 4'd0);
    // R5: reserved release on empty pool with allocate still fails
    step(1'b1, 1'b1, 3'd4);
    expect_out("R5", 1'b0, 3'd0, 1'b1, 1'b0, 4'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule